// File: doc/BRIEF.md
# Unlock Command Sequence Detector

This block sits on the byte-load path of a nonvolatile memory and watches every accepted load cycle (an address and a data byte). Write protection is always on. A program or write operation may begin only after a fixed three-cycle unlock prefix. The first two cycles are fixed key bytes at two fixed addresses. The third cycle carries a command byte. The block recognises the program command, and it also recognises the two commands that switch product identification mode on and off.

When the program command is recognised, the block pulses an arm strobe toward the load controller. That controller then owns the following loads and holds `loaderBusy` high while it does, so the detector ignores them. Any load that is not part of a valid prefix counts as an unauthorized write. It raises a one-cycle `timerStart` pulse, which starts the internal write timer so that reads turn into polling reads, and it stores nothing.

An identification entry or exit takes effect only after a pause of `PAUSE_CYCLES` clock edges. While identification mode is active, a read at address 0 returns the manufacturer code and a read at address 1 returns the device code. A synchronous power-on reset clears the prefix state and leaves identification mode off.

Top module: `unlock_seq_detect`

## Requirements
- R1: After synchronous reset, `progArm`, `timerStart`, `idMode`, `idBusy` and `idHit` are all 0. The reset also clears identification mode when it was active.
- R2: Three accepted loads arm the program path: data 0xAA at address 0x5555, then data 0x55 at 0x2AAA, then data 0xA0 at 0x5555. This gives exactly one `progArm` pulse, in the cycle after the third load, with no `timerStart`.
- R3: Only address bits 14..0 take part in the prefix match. Bits 18..15 of `loadAddr` have no effect.
- R4: An accepted load in the idle state that is not 0xAA at 0x5555 gives a one-cycle `timerStart` pulse in the next cycle and no `progArm`.
- R5: A load that breaks the prefix (a wrong second cycle, or a wrong third-cycle address) gives `timerStart` and returns the detector to idle, so a following command byte cannot arm.
- R6: A load of 0xAA at 0x5555 in any state restarts the prefix without a `timerStart` pulse.
- R7: The command byte 0x90 sets `idBusy` for `PAUSE_CYCLES` cycles. `idMode` rises on the edge that ends the pause.
- R8: The command byte 0xF0 clears `idMode` after the same pause.
- R9: Any third-cycle byte at 0x5555 other than 0xA0, 0x90, 0xF0 and 0xAA gives `timerStart` and no `progArm`.
- R10: While `idMode` is 1, `rdAddr` 0 gives `idHit`=1 and `idCode`=0x1F, and `rdAddr` 1 gives `idHit`=1 and `idCode`=0xB4. Every other address, and every address while `idMode` is 0, gives `idHit`=0 and `idCode`=0.
- R11: Loads made while `loaderBusy` is 1 cause no pulse and do not advance the prefix.
- R12: A new identification command issued during a pause replaces the pending change and restarts the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| loadValid | input | 1 | A byte-load cycle is presented this cycle |
| loaderBusy | input | 1 | The load controller owns the load stream; the detector ignores loads |
| loadAddr | input | ADDR_W | Address of the load cycle |
| loadData | input | 8 | Data of the load cycle |
| rdAddr | input | ADDR_W | Read address, used for identification reads |
| progArm | output | 1 | One-cycle pulse: program prefix recognised |
| timerStart | output | 1 | One-cycle pulse: unauthorized write, start the write timer |
| idMode | output | 1 | Identification mode active |
| idBusy | output | 1 | An identification mode change is pending |
| idHit | output | 1 | The current read is served with an identification code |
| idCode | output | 8 | Identification code for the current read, 0 when there is no hit |

## Verification
A wrong prefix state shows up on the next accepted load. It appears as a missing or spurious `progArm` or `timerStart` pulse exactly one cycle after that load. The bench therefore samples both pulses after every load, and it sweeps every third-cycle byte after a full prefix. A fault in the pause counter shifts the `idMode` edge away from the cycle it is expected in. A bad pending-mode register leaves the wrong mode after a replaced command. The bench also checks identification reads over the whole read address space.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  typedef enum logic [1:0] {S_IDLE, S_GOT1, S_GOT2} seqState_t;

  typedef struct packed {
    logic arm;
    logic badWrite;
    logic idEnter;
    logic idExit;
  } seqStrobe_t;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ID_IN  = 8'h90;
  localparam logic [7:0] CMD_ID_OUT = 8'hF0;
  localparam logic [7:0] CODE_MFR   = 8'h1F;
  localparam logic [7:0] CODE_DEV   = 8'hB4;
  localparam logic [14:0] ADDR_KEY_A = 15'h5555;
  localparam logic [14:0] ADDR_KEY_B = 15'h2AAA;
endpackage

// File: rtl/unlock_ctrl.sv
module unlock_ctrl
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CMP_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadValid,
  input  logic              loaderBusy,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  output seqStrobe_t        strobe
);
  localparam logic [CMP_W-1:0] MATCH_A = CMP_W'(ADDR_KEY_A);
  localparam logic [CMP_W-1:0] MATCH_B = CMP_W'(ADDR_KEY_B);

  seqState_t state, nextState;
  logic take, atA, atB, isKey1, isKey2;

  assign take   = loadValid && !loaderBusy;
  assign atA    = loadAddr[CMP_W-1:0] == MATCH_A;
  assign atB    = loadAddr[CMP_W-1:0] == MATCH_B;
  assign isKey1 = atA && (loadData == KEY_FIRST);
  assign isKey2 = atB && (loadData == KEY_SECOND);

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (take) begin
      if (isKey1) begin
        nextState = S_GOT1;
      end else begin
        nextState = S_IDLE;
        unique case (state)
          S_GOT1: begin
            if (isKey2) nextState = S_GOT2;
            else        strobe.badWrite = 1'b1;
          end
          S_GOT2: begin
            if (atA && loadData == CMD_PROG)        strobe.arm = 1'b1;
            else if (atA && loadData == CMD_ID_IN)  strobe.idEnter = 1'b1;
            else if (atA && loadData == CMD_ID_OUT) strobe.idExit = 1'b1;
            else                                    strobe.badWrite = 1'b1;
          end
          default: strobe.badWrite = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end

  // R6: the first key always restarts the prefix
  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (loadValid && !loaderBusy && loadAddr[CMP_W-1:0] == MATCH_A && loadData == KEY_FIRST)
      |=> state == S_GOT1);

  // R11: ignored loads leave the prefix state alone
  assert_hold_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (loaderBusy || !loadValid) |=> $stable(state));

  // R2: the program strobe only comes from the second-key state
  assert_arm_from_got2_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.arm |-> state == S_GOT2);
endmodule

// File: rtl/unlock_dp.sv
module unlock_dp
  import unlock_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int PAUSE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              progArm,
  output logic              timerStart,
  output logic              idMode,
  output logic              idBusy,
  output logic              idHit,
  output logic [7:0]        idCode
);
  localparam int CNT_W = $clog2(PAUSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] PAUSE_LOAD = CNT_W'(PAUSE_CYCLES);

  logic [CNT_W-1:0] pauseCnt;
  logic pendMode;

  always_ff @(posedge clk) begin
    if (rst) begin
      progArm    <= 1'b0;
      timerStart <= 1'b0;
      idMode     <= 1'b0;
      pendMode   <= 1'b0;
      pauseCnt   <= '0;
    end else begin
      progArm    <= strobe.arm;
      timerStart <= strobe.badWrite;
      if (strobe.idEnter || strobe.idExit) begin
        pauseCnt <= PAUSE_LOAD;
        pendMode <= strobe.idEnter;
      end else if (pauseCnt != '0) begin
        pauseCnt <= pauseCnt - 1'b1;
        if (pauseCnt == CNT_W'(1)) idMode <= pendMode;
      end
    end
  end

  assign idBusy = pauseCnt != '0;
  assign idHit  = idMode && (rdAddr[ADDR_W-1:1] == '0);
  assign idCode = idHit ? (rdAddr[0] ? CODE_DEV : CODE_MFR) : 8'h00;

  // R4: an unauthorized write never arms in the same cycle
  assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(progArm && timerStart));

  // R7: the mode only moves at the end of a pause
  assert_mode_at_pause_end_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(idMode) |-> $past(pauseCnt) == CNT_W'(1));

  // R12: every identification command (re)starts the pause
  assert_busy_after_cmd_R12: assert property (@(posedge clk) disable iff (rst)
    (strobe.idEnter || strobe.idExit) |=> idBusy);

  // R10: codes appear only in identification mode
  assert_code_needs_mode_R10: assert property (@(posedge clk) disable iff (rst)
    (idCode != 8'h00) |-> idMode);
endmodule

// File: rtl/unlock_seq_detect.sv
module unlock_seq_detect
  import unlock_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int CMP_W        = 15,
  parameter int PAUSE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadValid,
  input  logic              loaderBusy,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              progArm,
  output logic              timerStart,
  output logic              idMode,
  output logic              idBusy,
  output logic              idHit,
  output logic [7:0]        idCode
);
  seqStrobe_t strobe;

  unlock_ctrl #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_ctrl (
    .clk(clk), .rst(rst), .loadValid(loadValid), .loaderBusy(loaderBusy),
    .loadAddr(loadAddr), .loadData(loadData), .strobe(strobe)
  );

  unlock_dp #(.ADDR_W(ADDR_W), .PAUSE_CYCLES(PAUSE_CYCLES)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .rdAddr(rdAddr),
    .progArm(progArm), .timerStart(timerStart), .idMode(idMode),
    .idBusy(idBusy), .idHit(idHit), .idCode(idCode)
  );
endmodule

// File: tb/sim_unlock_seq_detect.sv
module sim_unlock_seq_detect;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 19;
  localparam int PAUSE = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadValid = 1'b0;
  logic loaderBusy = 1'b0;
  logic [ADDR_W-1:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic progArm, timerStart, idMode, idBusy, idHit;
  logic [7:0] idCode;

  int nRun = 0;
  int nFail = 0;
  logic gArm, gTmr;

  always #(CLK_PERIOD/2) clk = ~clk;

  unlock_seq_detect #(.ADDR_W(ADDR_W), .CMP_W(15), .PAUSE_CYCLES(PAUSE)) u0 (
    .clk(clk), .rst(rst), .loadValid(loadValid), .loaderBusy(loaderBusy),
    .loadAddr(loadAddr), .loadData(loadData), .rdAddr(rdAddr),
    .progArm(progArm), .timerStart(timerStart), .idMode(idMode),
    .idBusy(idBusy), .idHit(idHit), .idCode(idCode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doLoad(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    loadValid = 1'b1; loadAddr = a; loadData = d;
    @(negedge clk);
    loadValid = 1'b0;
    gArm = progArm; gTmr = timerStart;
  endtask

  task automatic prefix(input logic [7:0] cmd);
    doLoad(19'h05555, 8'hAA);
    doLoad(19'h02AAA, 8'h55);
    doLoad(19'h05555, cmd);
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    nFail++; nRun++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    waitNeg(3);
    rst = 1'b0;
    // R1 reset state
    chk(!progArm && !timerStart, "R1 pulses", {progArm, timerStart}, 0);
    chk(!idMode && !idBusy && !idHit, "R1 mode", {idMode, idBusy, idHit}, 0);

    // R2 program prefix
    doLoad(19'h05555, 8'hAA);
    chk(!gArm && !gTmr, "R2 first key", {gArm, gTmr}, 0);
    doLoad(19'h02AAA, 8'h55);
    chk(!gArm && !gTmr, "R2 second key", {gArm, gTmr}, 0);
    doLoad(19'h05555, 8'hA0);
    chk(gArm && !gTmr, "R2 arm", {gArm, gTmr}, 2);
    @(negedge clk);
    chk(!progArm, "R2 single pulse", progArm, 0);

    // R3 upper address bits ignored
    doLoad(19'h75555, 8'hAA);
    doLoad(19'h3AAAA, 8'h55);
    doLoad(19'h45555, 8'hA0);
    chk(gArm && !gTmr, "R3 upper bits", {gArm, gTmr}, 2);

    // R4 stray write from idle
    doLoad(19'h01234, 8'h00);
    chk(gTmr && !gArm, "R4 stray", {gArm, gTmr}, 1);
    @(negedge clk);
    chk(!timerStart, "R4 single pulse", timerStart, 0);
    doLoad(19'h05555, 8'hA0);
    chk(gTmr && !gArm, "R4 command alone", {gArm, gTmr}, 1);

    // R5 broken prefix
    doLoad(19'h05555, 8'hAA);
    doLoad(19'h02AAA, 8'h00);
    chk(gTmr, "R5 bad second", gTmr, 1);
    doLoad(19'h05555, 8'hA0);
    chk(gTmr && !gArm, "R5 no arm after break", {gArm, gTmr}, 1);
    doLoad(19'h05555, 8'hAA);
    doLoad(19'h02AAA, 8'h55);
    doLoad(19'h01555, 8'hA0);
    chk(gTmr && !gArm, "R5 bad third address", {gArm, gTmr}, 1);

    // R6 restart in GOT1 and GOT2
    doLoad(19'h05555, 8'hAA);
    doLoad(19'h05555, 8'hAA);
    chk(!gTmr, "R6 restart got1", gTmr, 0);
    doLoad(19'h02AAA, 8'h55);
    doLoad(19'h05555, 8'hAA);
    chk(!gTmr && !gArm, "R6 restart got2", {gArm, gTmr}, 0);
    doLoad(19'h02AAA, 8'h55);
    doLoad(19'h05555, 8'hA0);
    chk(gArm && !gTmr, "R6 arm after restart", {gArm, gTmr}, 2);

    // R9 sweep of the third byte
    for (int d = 0; d < 256; d++) begin
      if (d == 8'h90 || d == 8'hF0 || d == 8'hAA) continue;
      prefix(8'(d));
      if (d == 8'hA0) chk(gArm && !gTmr, "R9 sweep arm", {gArm, gTmr}, 2);
      else            chk(!gArm && gTmr, "R9 sweep reject", {gArm, gTmr}, 1);
    end
    chk(!idMode && !idBusy, "R9 no mode change", {idMode, idBusy}, 0);

    // R7 enter identification
    prefix(8'h90);
    chk(!gArm && !gTmr, "R7 no pulse", {gArm, gTmr}, 0);
    chk(idBusy && !idMode, "R7 pause start", {idMode, idBusy}, 1);
    waitNeg(PAUSE - 1);
    chk(idBusy && !idMode, "R7 pause last", {idMode, idBusy}, 1);
    @(negedge clk);
    chk(idMode && !idBusy, "R7 mode on", {idMode, idBusy}, 2);

    // R10 read sweep in identification mode
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      logic expHit;
      logic [7:0] expCode;
      rdAddr = ADDR_W'(a);
      #1;
      expHit = (a >> 1) == 0;
      expCode = !expHit ? 8'h00 : ((a & 1) != 0 ? 8'hB4 : 8'h1F);
      if (idHit !== expHit || idCode !== expCode) begin
        chk(1'b0, "R10 id read", {idHit, idCode}, {expHit, expCode});
      end else if (a < 4) begin
        chk(1'b1, "R10 id read", 0, 0);
      end
    end
    rdAddr = '0;

    // R8 exit identification
    prefix(8'hF0);
    chk(idMode && idBusy, "R8 still on during pause", {idMode, idBusy}, 3);
    waitNeg(PAUSE);
    chk(!idMode && !idBusy, "R8 mode off", {idMode, idBusy}, 0);
    #1;
    chk(!idHit && idCode == 8'h00, "R10 no hit when off", {idHit, idCode}, 0);

    // R12 command replaced during the pause
    prefix(8'h90);
    prefix(8'hF0);
    waitNeg(PAUSE - 6);
    chk(!idMode && idBusy, "R12 old pause end", {idMode, idBusy}, 1);
    waitNeg(6);
    chk(!idMode && !idBusy, "R12 last wins", {idMode, idBusy}, 0);

    // R11 loads ignored while the loader is busy
    loaderBusy = 1'b1;
    prefix(8'hA0);
    chk(!gArm && !gTmr, "R11 busy prefix", {gArm, gTmr}, 0);
    doLoad(19'h01234, 8'h77);
    chk(!gTmr, "R11 busy stray", gTmr, 0);
    doLoad(19'h05555, 8'hAA);
    loaderBusy = 1'b0;
    doLoad(19'h02AAA, 8'h55);
    chk(gTmr && !gArm, "R11 no progress", {gArm, gTmr}, 1);

    // R1 reset clears identification mode
    prefix(8'h90);
    waitNeg(PAUSE);
    chk(idMode, "R1 setup mode", idMode, 1);
    rst = 1'b1;
    waitNeg(2);
    rst = 1'b0;
    chk(!idMode && !idBusy, "R1 reset clears mode", {idMode, idBusy}, 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule